// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel. Software loads a source address, a destination address, a unit count and a control word through a small word-addressed register port. Once the channel is enabled, it asks an external arbiter for the bus. After the grant, it moves data one unit at a time: a read from the source, then a write of the same data to the destination. After each unit, each address steps according to its own mode and the unit size, and the counter drops by one.

When the counter runs out, the channel sets a completion flag and stops. It can also raise an interrupt. Two bus modes are offered. In the first, the bus is released after every unit. In the second, the bus is held for the whole transfer. A unit may start on its own, or only while an external request line is high. A reserved address mode does not transfer anything. Instead it raises an address-error indication. An optional source-reload feature returns the source address to its programmed value after each completed transfer.

Top module: `dma_chan_engine`

## Requirements
- R1: The register port selects a word with `reg_addr`: 0 is the source address, 1 the destination address, 2 the 24-bit unit counter (upper read bits zero), 3 the control word. All four read zero after reset, and `irq`, `bus_req` and `addr_err` are low.
- R2: Control word layout: bit 0 enable, bit 1 done flag, bit 2 interrupt enable, bits 4:3 unit size code, bit 5 burst, bits 7:6 source mode, bits 9:8 destination mode, bit 10 external-request select, bit 11 source reload, bit 12 address error (read only). Bits 31:13 read zero.
- R3: The counter decrements by one per unit moved, and the transfer ends when it would reach zero. A loaded zero counts as 2^24 units, so after one unit the counter reads 0xFFFFFF.
- R4: Address mode code 0 keeps the address fixed, 1 adds the unit size and 2 subtracts it after every unit. Size codes 0, 1, 2, 3 mean 1, 2, 4 and 16 bytes.
- R5: Each unit is one read at the current source address followed by one write at the current destination address. The write carries the read data, and `mem_size` carries the size code.
- R6: With burst 0, `bus_req` falls after every unit, so an N-unit transfer raises it N times. With burst 1, it stays high from the first unit to the last.
- R7: A unit starts only when all of these hold: enable is set, the done flag is clear, the address-error flag is clear, `master_en` is high, and either external select is 0 or `ext_dreq` is high.
- R8: After the last unit the done flag is set and the channel stops, even with enable still set. Writing 0 to bit 1 clears the flag, and writing 1 leaves it unchanged. `irq` equals the done flag AND the interrupt-enable bit.
- R9: A source or destination mode of 3 makes a start attempt set the address-error flag (`addr_err` and bit 12) instead of transferring. Writing the control word with enable 0 clears the flag.
- R10: With source reload set, the source address returns to the last value software wrote to it when the transfer completes.
- R11: Register writes have no effect while the channel holds `bus_req`.
- R12: `mem_req` is only asserted while `bus_gnt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Global enable for starting units |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_dreq | input | 1 | External transfer request level |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Unit size code of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| irq | output | 1 | Completion interrupt |
| addr_err | output | 1 | Address-error indication |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, a 24-bit counter, a 128-bit data path and source reload present. The small three-unit transfer length lets it sweep every combination of unit size, source mode, destination mode and bus mode. For each combination it checks every read and write address and every write data word against arithmetic predictions. The loaded-zero count, which would otherwise need 2^24 units, is brought within reach by gating units with the external request line and stopping after one unit.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'd0,
    AM_INC   = 2'd1,
    AM_DEC   = 2'd2,
    AM_RSVD  = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_RD   = 2'd2,
    ST_WR   = 2'd3
  } chan_state_e;

  // Control word, bit 11 down to bit 0
  typedef struct packed {
    logic       reload;
    logic       ext_sel;
    addr_mode_e dmode;
    addr_mode_e smode;
    logic       burst;
    logic [1:0] size;
    logic       ie;
    logic       te;
    logic       en;
  } chan_ctrl_t;

  localparam int CTRL_W   = 12;
  localparam int REG_W    = 32;
  localparam int AERR_BIT = 12;

  localparam logic [1:0] RA_SRC  = 2'd0;
  localparam logic [1:0] RA_DST  = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;

  function automatic logic [4:0] unit_bytes(input logic [1:0] code);
    return (code == 2'd3) ? 5'd16 : (5'd1 << code);
  endfunction

endpackage

// File: rtl/dma_chan_addr_step.sv
module dma_chan_addr_step
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  addr_mode_e        mode,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] nxt_addr
);

  logic [ADDR_W-1:0] step;

  always_comb begin
    step = ADDR_W'(unit_bytes(size));
    unique case (mode)
      AM_INC:  nxt_addr = cur_addr + step;
      AM_DEC:  nxt_addr = cur_addr - step;
      default: nxt_addr = cur_addr;
    endcase
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 24,
  parameter bit HAS_SRC_RELOAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              active,
  input  logic              unit_done,
  input  logic              last_unit,
  input  logic              aerr_set,
  input  logic [ADDR_W-1:0] src_step,
  input  logic [ADDR_W-1:0] dst_step,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output chan_ctrl_t        ctrl_q,
  output logic              aerr_q
);

  logic              sw_wr;
  logic              wr_src, wr_dst, wr_cnt, wr_ctrl;
  logic              finish;
  logic [ADDR_W-1:0] src_d, dst_d, base_addr;
  logic [CNT_W-1:0]  cnt_d;
  chan_ctrl_t        ctrl_d;
  logic              aerr_d;
  logic              src_ce, dst_ce, cnt_ce, ctrl_ce, aerr_ce;
  logic              reload_on;

  assign sw_wr   = reg_we & ~active;
  assign wr_src  = sw_wr & (reg_addr == RA_SRC);
  assign wr_dst  = sw_wr & (reg_addr == RA_DST);
  assign wr_cnt  = sw_wr & (reg_addr == RA_CNT);
  assign wr_ctrl = sw_wr & (reg_addr == RA_CTRL);
  assign finish  = unit_done & last_unit;

  generate
    if (HAS_SRC_RELOAD) begin : g_reload
      logic [ADDR_W-1:0] base_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      base_q <= '0;
        else if (wr_src) base_q <= reg_wdata[ADDR_W-1:0];
      end
      assign base_addr = base_q;
      assign reload_on = ctrl_q.reload;
    end else begin : g_no_reload
      assign base_addr = src_step;
      assign reload_on = 1'b0;
    end
  endgenerate

  // next-state
  always_comb begin
    src_ce  = wr_src | unit_done;
    dst_ce  = wr_dst | unit_done;
    cnt_ce  = wr_cnt | unit_done;
    ctrl_ce = wr_ctrl | finish;
    aerr_ce = aerr_set | (wr_ctrl & ~reg_wdata[0]);

    src_d = src_step;
    if (wr_src)                     src_d = reg_wdata[ADDR_W-1:0];
    else if (finish && reload_on)   src_d = base_addr;

    dst_d = wr_dst ? reg_wdata[ADDR_W-1:0] : dst_step;
    cnt_d = wr_cnt ? reg_wdata[CNT_W-1:0] : (cnt_q - CNT_W'(1));

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d    = chan_ctrl_t'(reg_wdata[CTRL_W-1:0]);
      ctrl_d.te = ctrl_q.te & reg_wdata[1];
      if (!HAS_SRC_RELOAD) ctrl_d.reload = 1'b0;
    end
    if (finish) ctrl_d.te = 1'b1;

    aerr_d = aerr_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      aerr_q <= 1'b0;
    end else begin
      if (src_ce)  src_q  <= src_d;
      if (dst_ce)  dst_q  <= dst_d;
      if (cnt_ce)  cnt_q  <= cnt_d;
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (aerr_ce) aerr_q <= aerr_d;
    end
  end

  // read mux
  always_comb begin
    unique case (reg_addr)
      RA_SRC:  reg_rdata = REG_W'(src_q);
      RA_DST:  reg_rdata = REG_W'(dst_q);
      RA_CNT:  reg_rdata = REG_W'(cnt_q);
      default: reg_rdata = {{(REG_W-AERR_BIT-1){1'b0}}, aerr_q, ctrl_q};
    endcase
  end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              te,
  input  logic              burst,
  input  logic              ext_sel,
  input  addr_mode_e        smode,
  input  addr_mode_e        dmode,
  input  logic [1:0]        size,
  input  logic              aerr,
  input  logic              master_en,
  input  logic              ext_dreq,
  input  logic              bus_gnt,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] src_q,
  input  logic [ADDR_W-1:0] dst_q,
  output logic              bus_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              unit_done,
  output logic              last_unit,
  output logic              aerr_set,
  output logic              active
);

  chan_state_e       state_q, state_d;
  logic [DATA_W-1:0] hold_q;
  logic              hold_ce;
  logic              may_go, bad_mode;

  assign may_go   = en & ~te & ~aerr & master_en & (~ext_sel | ext_dreq);
  assign bad_mode = (smode == AM_RSVD) | (dmode == AM_RSVD);

  assign last_unit = (cnt_q == CNT_W'(1));
  assign unit_done = (state_q == ST_WR) & mem_ack;
  assign hold_ce   = (state_q == ST_RD) & mem_ack;
  assign aerr_set  = (state_q == ST_IDLE) & may_go & bad_mode;

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (may_go && !bad_mode) state_d = ST_ARB;
      ST_ARB:  if (bus_gnt)             state_d = ST_RD;
      ST_RD:   if (mem_ack)             state_d = ST_WR;
      ST_WR: begin
        if (mem_ack) begin
          if (!last_unit && burst) state_d = ST_RD;
          else                     state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (hold_ce) hold_q <= mem_rdata;
    end
  end

  assign active    = (state_q != ST_IDLE);
  assign bus_req   = active;
  assign mem_req   = (state_q == ST_RD) | (state_q == ST_WR);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = (state_q == ST_WR) ? dst_q : src_q;
  assign mem_size  = size;
  assign mem_wdata = hold_q;

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CNT_W          = 24,
  parameter int DATA_W         = 128,
  parameter bit HAS_SRC_RELOAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ext_dreq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq,
  output logic              addr_err
);

  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic              active, unit_done, last_unit, aerr_set, aerr_q;
  logic [ADDR_W-1:0] src_q, dst_q, src_step, dst_step;
  logic [CNT_W-1:0]  cnt_q;
  chan_ctrl_t        ctrl_q;
  logic              te_flag;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .HAS_SRC_RELOAD(HAS_SRC_RELOAD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_int),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .active(active), .unit_done(unit_done), .last_unit(last_unit),
    .aerr_set(aerr_set), .src_step(src_step), .dst_step(dst_step),
    .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q),
    .aerr_q(aerr_q)
  );

  dma_chan_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .cur_addr(src_q), .mode(ctrl_q.smode), .size(ctrl_q.size),
    .nxt_addr(src_step)
  );

  dma_chan_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .cur_addr(dst_q), .mode(ctrl_q.dmode), .size(ctrl_q.size),
    .nxt_addr(dst_step)
  );

  dma_chan_ctl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n_int),
    .en(ctrl_q.en), .te(ctrl_q.te), .burst(ctrl_q.burst),
    .ext_sel(ctrl_q.ext_sel), .smode(ctrl_q.smode), .dmode(ctrl_q.dmode),
    .size(ctrl_q.size), .aerr(aerr_q),
    .master_en(master_en), .ext_dreq(ext_dreq), .bus_gnt(bus_gnt),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
    .bus_req(bus_req), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .unit_done(unit_done), .last_unit(last_unit), .aerr_set(aerr_set),
    .active(active)
  );

  assign te_flag  = ctrl_q.te;
  assign irq      = ctrl_q.te & ctrl_q.ie;
  assign addr_err = aerr_q;

endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_en,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic             irq,
  input logic             te_flag,
  input logic             addr_err,
  input logic [CNT_W-1:0] cnt
);

  assert_mem_under_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> bus_gnt);

  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  assert_start_needs_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(master_en));

  assert_count_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (cnt == $past(cnt) - 1'b1));

  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> te_flag);

  assert_done_releases_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_flag) |-> !bus_req);

  assert_error_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> !mem_req);

endmodule

bind dma_chan_engine dma_chan_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_en(master_en), .bus_req(bus_req),
  .bus_gnt(bus_gnt), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .irq(irq), .te_flag(te_flag), .addr_err(addr_err), .cnt(cnt_q)
);

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         master_en;
  logic         reg_we;
  logic [1:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         ext_dreq;
  logic         bus_req, bus_gnt;
  logic         mem_req, mem_we, mem_ack;
  logic [31:0]  mem_addr;
  logic [1:0]   mem_size;
  logic [127:0] mem_wdata, mem_rdata;
  logic         irq, addr_err;
  logic         gnt_allow;

  int errors = 0;
  int checks = 0;
  int k      = 0;
  int rises  = 0;
  logic prev_req = 1'b0;

  int cur_sz, cur_sm, cur_dm;
  logic [31:0] src_base, dst_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] model(input logic [31:0] a);
    return {a ^ 32'hC3C3_0000, ~a, a + 32'h1234, a};
  endfunction

  assign bus_gnt   = bus_req & gnt_allow;
  assign mem_ack   = mem_req;
  assign mem_rdata = model(mem_addr);

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ext_dreq(ext_dreq),
    .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq), .addr_err(addr_err)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base,
      input int mode, input int sz, input int n);
    int st;
    st = (sz == 3) ? 16 : (1 << sz);
    case (mode)
      1:       return base + 32'(n * st);
      2:       return base - 32'(n * st);
      default: return base;
    endcase
  endfunction

  function automatic logic [31:0] mk_ctrl(input bit en, input bit ie,
      input int sz, input bit burst, input int sm, input int dm,
      input bit ext, input bit rel);
    return {20'd0, rel, ext, 2'(dm), 2'(sm), burst, 2'(sz), ie, 1'b0, en};
  endfunction

  // bus and memory monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
      if (mem_req && mem_ack) begin
        if (!mem_we) begin
          chk(mem_addr == exp_addr(src_base, cur_sm, cur_sz, k),
              "R4 read address", mem_addr, exp_addr(src_base, cur_sm, cur_sz, k));
        end else begin
          chk(mem_addr == exp_addr(dst_base, cur_dm, cur_sz, k),
              "R4 write address", mem_addr, exp_addr(dst_base, cur_dm, cur_sz, k));
          chk(mem_wdata == model(exp_addr(src_base, cur_sm, cur_sz, k)),
              "R5 write data", mem_wdata, model(exp_addr(src_base, cur_sm, cur_sz, k)));
          chk(mem_size == 2'(cur_sz), "R5 size code", mem_size, cur_sz);
          k++;
        end
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 400; i++) begin
      rd(2'd3, v);
      if (v[1]) break;
    end
    chk(v[1] == 1'b1, "R8 done flag set", v, 32'h2);
  endtask

  task automatic setup(input int sz, input int sm, input int dm,
                       input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    cur_sz = sz; cur_sm = sm; cur_dm = dm;
    src_base = s; dst_base = d;
    wr(2'd0, s);
    wr(2'd1, d);
    wr(2'd2, n);
    k = 0; rises = 0;
  endtask

  task automatic run_cfg(input int sz, input int sm, input int dm, input bit burst);
    logic [31:0] v;
    setup(sz, sm, dm, 32'h1000_0100, 32'h2000_0800, 32'd3);
    wr(2'd3, mk_ctrl(1, 1, sz, burst, sm, dm, 0, 0));
    wait_done();
    chk(k == 3, "R5 units moved", k, 3);
    rd(2'd2, v);
    chk(v == 0, "R3 count at end", v, 0);
    rd(2'd0, v);
    chk(v == exp_addr(src_base, sm, sz, 3), "R4 final source", v, exp_addr(src_base, sm, sz, 3));
    rd(2'd1, v);
    chk(v == exp_addr(dst_base, dm, sz, 3), "R4 final destination", v, exp_addr(dst_base, dm, sz, 3));
    chk(rises == (burst ? 1 : 3), "R6 bus request count", rises, burst ? 1 : 3);
    chk(irq == 1'b1, "R8 irq", irq, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; master_en = 1'b1; reg_we = 1'b0; reg_addr = '0;
    reg_wdata = '0; ext_dreq = 1'b0; gnt_allow = 1'b1;
    cur_sz = 0; cur_sm = 0; cur_dm = 0; src_base = '0; dst_base = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk({irq, bus_req, addr_err} == 3'b000, "R1 outputs after reset", {irq, bus_req, addr_err}, 0);

    // R2 layout readback, done flag cannot be set by software
    wr(2'd3, 32'hFFFF_FFFE);
    rd(2'd3, v);
    chk(v == 32'h0000_0FFC, "R2 control readback", v, 32'h0FFC);
    wr(2'd3, 32'h0);

    // R7 master enable gate
    master_en = 1'b0;
    setup(0, 1, 1, 32'h40, 32'h80, 32'd2);
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 1, 1, 0, 0));
    repeat (8) @(negedge clk);
    chk(rises == 0, "R7 no start without master enable", rises, 0);
    rd(2'd2, v);
    chk(v == 2, "R7 count untouched", v, 2);
    master_en = 1'b1;
    wait_done();
    chk(k == 2, "R7 runs once master enabled", k, 2);
    chk(irq == 1'b0, "R8 irq masked by ie=0", irq, 0);

    // R8 no restart while done flag set
    rises = 0;
    repeat (6) @(negedge clk);
    chk(rises == 0, "R8 stays stopped", rises, 0);

    // R7 external request gate
    setup(1, 2, 1, 32'h600, 32'h900, 32'd2);
    wr(2'd3, mk_ctrl(1, 0, 1, 0, 2, 1, 1, 0));
    repeat (8) @(negedge clk);
    chk(rises == 0, "R7 no start without external request", rises, 0);
    ext_dreq = 1'b1;
    wait_done();
    chk(k == 2, "R7 units with external request", k, 2);
    ext_dreq = 1'b0;

    // R3 loaded zero means maximum count
    setup(0, 1, 1, 32'hA00, 32'hB00, 32'd0);
    ext_dreq = 1'b1;
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 1, 1, 1, 0));
    wait (k == 1);
    ext_dreq = 1'b0;
    repeat (8) @(negedge clk);
    rd(2'd2, v);
    chk(v == 32'h00FF_FFFF, "R3 zero count wraps to max", v, 32'hFFFFFF);
    rd(2'd3, v);
    chk(v[1] == 1'b0, "R3 not done after one unit", v[1], 0);
    chk(k == 1, "R3 one unit moved", k, 1);
    wr(2'd3, 32'h0);

    // R11 writes ignored while holding the bus
    gnt_allow = 1'b0;
    setup(2, 1, 0, 32'h3000, 32'h4000, 32'd1);
    wr(2'd3, mk_ctrl(1, 0, 2, 0, 1, 0, 0, 0));
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b1, "R11 waiting for grant", bus_req, 1);
    wr(2'd0, 32'hDEAD_0000);
    rd(2'd0, v);
    chk(v == 32'h3000, "R11 source write ignored", v, 32'h3000);
    gnt_allow = 1'b1;
    wait_done();

    // R9 reserved mode
    setup(0, 3, 1, 32'h100, 32'h200, 32'd5);
    wr(2'd3, mk_ctrl(1, 0, 0, 0, 3, 1, 0, 0));
    repeat (5) @(negedge clk);
    chk(addr_err == 1'b1, "R9 address error output", addr_err, 1);
    chk(rises == 0, "R9 no transfer", rises, 0);
    rd(2'd3, v);
    chk(v[12] == 1'b1, "R9 error bit readback", v[12], 1);
    rd(2'd2, v);
    chk(v == 5, "R9 count unchanged", v, 5);
    wr(2'd3, 32'h0);
    chk(addr_err == 1'b0, "R9 error cleared", addr_err, 0);

    // R10 source reload
    setup(2, 1, 1, 32'h300, 32'h700, 32'd3);
    wr(2'd3, mk_ctrl(1, 1, 2, 1, 1, 1, 0, 1));
    wait_done();
    rd(2'd0, v);
    chk(v == 32'h300, "R10 source restored", v, 32'h300);
    rd(2'd1, v);
    chk(v == 32'h70C, "R10 destination advanced", v, 32'h70C);

    // R8 done flag write semantics and irq
    chk(irq == 1'b1, "R8 irq with ie", irq, 1);
    wr(2'd3, 32'h0000_0006);
    rd(2'd3, v);
    chk(v[1] == 1'b1, "R8 writing 1 keeps done", v[1], 1);
    chk(irq == 1'b1, "R8 irq kept", irq, 1);
    wr(2'd3, 32'h0000_0002);
    chk(irq == 1'b0, "R8 irq off without ie", irq, 0);
    wr(2'd3, 32'h0000_0004);
    rd(2'd3, v);
    chk(v[1] == 1'b0, "R8 writing 0 clears done", v[1], 0);
    chk(irq == 1'b0, "R8 irq off after clear", irq, 0);

    // R4 R5 R6 full sweep
    for (int sz = 0; sz < 4; sz++)
      for (int sm = 0; sm < 3; sm++)
        for (int dm = 0; dm < 3; dm++)
          for (int b = 0; b < 2; b++)
            run_cfg(sz, sm, dm, b[0]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule